// File: doc/BRIEF.md
# Neural Accelerator Instruction Sequencer

This block controls one processing element of a small neural-network accelerator. A host processor builds a 192-bit instruction in six 32-bit words through a memory-mapped register port. The port has separate write and read enables. The host then writes a start register. The sequencer decodes an 8-bit operation code and a one-bit memory-mode flag from the instruction. It steps through four phases in a fixed order: memory fetch, data-buffer unpack, ALU compute and result write-back.

Each phase raises a request toward its unit and holds it until that unit acknowledges. The memory, data buffer and ALU lie outside the block; only these request/acknowledge ports stand in for them. A status register goes from Idle to Running to Done. The host polls this register, and a poll that sees Done returns the register to Idle. A cycle counter for each phase records how long that phase lasted, and the host can read it back.

Top module: `pe_seq_ctrl`

## Requirements
- R1: A host write to address k (0 to 5) loads bits [32k+31:32k] of the instruction. A host read returns, one clock after the read enable, the value that was addressed; `host_rdata` holds its value on cycles with no read.
- R2: After reset the status is Idle (2'b00), all four phase requests are low, every phase counter reads zero and `host_rdata` is zero.
- R3: A write to address 6 with data bit 0 set starts execution when the status is not Running: on the next cycle the status is Running (2'b01) and `mem_req` is high. A start while Running, or a write to address 6 with bit 0 clear, has no effect.
- R4: While `mem_req` is high, `mem_random` equals instruction bit 8 (1 = random access pattern, 0 = sequential). Each request stays high until its acknowledge is sampled high.
- R5: Phases run in the order fetch (`mem_req`), unpack (`buf_req`), compute (`alu_req`, with `alu_op` = instruction bits [7:0]) and write-back (`wb_req`). The next request rises in the cycle after the acknowledge. Exactly one request is high while Running, and acknowledges outside an active phase are ignored.
- R6: The cycle after `wb_ack` is accepted, the status is Done (2'b10) and no request is high.
- R7: A read of address 7 returns the status in bits [1:0]. A read that returns Done sets the status to Idle, unless a start is accepted in the same cycle. A start issued while the status is Done is accepted.
- R8: Reads of addresses 8, 9, 10 and 11 return the cycle counts of fetch, unpack, compute and write-back. Each count includes the cycle in which the acknowledge arrives. All counts clear when a start is accepted, and each count saturates at 2^CNT_W-1.
- R9: Writes to the instruction words are ignored while Running, so `alu_op`, `mem_random` and readback stay unchanged.
- R10: Reads of address 6 and of unmapped addresses (12 to 15) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Register write select |
| host_rd_en | input | 1 | Register read select |
| host_addr | input | ADDR_W | Register word address |
| host_wdata | input | WORD_W | Write data |
| host_rdata | output | WORD_W | Registered read data |
| instr | output | WORD_W*N_WORDS | Assembled instruction presented to the datapath |
| mem_req | output | 1 | Fetch phase request to the memory access unit |
| mem_random | output | 1 | Access pattern: 1 random, 0 sequential |
| mem_ack | input | 1 | Fetch acknowledge |
| buf_req | output | 1 | Unpack request to the data buffer |
| buf_ack | input | 1 | Unpack acknowledge |
| alu_req | output | 1 | Compute request to the ALU |
| alu_op | output | OP_W | Decoded operation code |
| alu_ack | input | 1 | Compute acknowledge |
| wb_req | output | 1 | Write-back request |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
The bench keeps the default word width, word count and address width, but builds the block with CNT_W = 8. At that width a compute phase held for about 300 cycles drives its counter into saturation within a short run. With the default width of 16 this corner would need tens of thousands of cycles. Responder latencies of zero place acknowledges in the first cycle of a phase, and a second start placed directly on a Done status exercises the restart path.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int unsigned N_PHASES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } status_e;
endpackage

// File: rtl/seq_instr_regs.sv
module seq_instr_regs #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 6,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    input  logic                             lock,
    output logic [N_WORDS-1:0][WORD_W-1:0]   words
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wr_en && !lock && addr == ADDR_W'(g)) begin
                w_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end

        assign words[g] = w_q;
    end
endmodule

// File: rtl/seq_phase_cnt.sv
module seq_phase_cnt #(
    parameter int unsigned NP    = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic [NP-1:0]               active,
    output logic [NP-1:0][CNT_W-1:0]    cnt
);
    for (genvar g = 0; g < NP; g++) begin : g_cnt
        logic [CNT_W-1:0] c_d, c_q;

        always_comb begin
            c_d = c_q;
            if (clr) begin
                c_d = '0;
            end else if (active[g] && c_q != {CNT_W{1'b1}}) begin
                c_d = c_q + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign cnt[g] = c_q;
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int unsigned NP = N_PHASES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          stat_clr,
    input  logic [NP-1:0] ack,
    output status_e       status,
    output logic [NP-1:0] req,
    output logic          start
);
    typedef struct packed {
        status_e       st;
        logic [NP-1:0] ph;
    } fsm_t;

    localparam logic [NP-1:0] FIRST_PH = NP'(1);

    fsm_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        if (s_q.st == ST_RUN) begin
            if (|(s_q.ph & ack)) begin
                s_d.ph = s_q.ph << 1;
                if (s_q.ph[NP-1]) s_d.st = ST_DONE;
            end
        end else if (go) begin
            s_d.st = ST_RUN;
            s_d.ph = FIRST_PH;
            start  = 1'b1;
        end else if (stat_clr && s_q.st == ST_DONE) begin
            s_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, ph: '0};
        else        s_q <= s_d;
    end

    assign status = s_q.st;
    assign req    = s_q.ph;
endmodule

// File: rtl/pe_seq_ctrl.sv
module pe_seq_ctrl
    import seq_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned N_WORDS  = 6,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned OP_W     = 8,
    parameter int unsigned MODE_BIT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr_en,
    input  logic                      host_rd_en,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [WORD_W-1:0]         host_wdata,
    output logic [WORD_W-1:0]         host_rdata,
    output logic [WORD_W*N_WORDS-1:0] instr,
    output logic                      mem_req,
    output logic                      mem_random,
    input  logic                      mem_ack,
    output logic                      buf_req,
    input  logic                      buf_ack,
    output logic                      alu_req,
    output logic [OP_W-1:0]           alu_op,
    input  logic                      alu_ack,
    output logic                      wb_req,
    input  logic                      wb_ack
);
    localparam int unsigned NP        = N_PHASES;
    localparam int unsigned GO_ADDR   = N_WORDS;
    localparam int unsigned STAT_ADDR = N_WORDS + 1;
    localparam int unsigned CNT_BASE  = N_WORDS + 2;

    logic [N_WORDS-1:0][WORD_W-1:0] words;
    logic [NP-1:0][CNT_W-1:0]       cnt;
    logic [NP-1:0]                  req, ack;
    status_e                        st;
    logic                           go, stat_clr, start;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_t;
    rd_t r_d, r_q;
    logic [WORD_W-1:0] rd_val;

    assign go       = host_wr_en && host_addr == ADDR_W'(GO_ADDR) && host_wdata[0];
    assign stat_clr = host_rd_en && host_addr == ADDR_W'(STAT_ADDR);
    assign ack      = {wb_ack, alu_ack, buf_ack, mem_ack};

    seq_instr_regs #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
        .wdata(host_wdata), .lock(st == ST_RUN), .words(words)
    );

    seq_fsm #(.NP(NP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .stat_clr(stat_clr), .ack(ack),
        .status(st), .req(req), .start(start)
    );

    seq_phase_cnt #(.NP(NP), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start), .active(req), .cnt(cnt)
    );

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (host_addr == ADDR_W'(k)) rd_val = words[k];
        end
        if (host_addr == ADDR_W'(STAT_ADDR)) rd_val = WORD_W'(st);
        for (int p = 0; p < NP; p++) begin
            if (host_addr == ADDR_W'(CNT_BASE + p)) rd_val = WORD_W'(cnt[p]);
        end
    end

    always_comb begin
        r_d = r_q;
        if (host_rd_en) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign host_rdata = r_q.rdata;
    assign instr      = words;
    assign alu_op     = words[0][OP_W-1:0];
    assign mem_random = words[0][MODE_BIT];
    assign mem_req    = req[0];
    assign buf_req    = req[1];
    assign alu_req    = req[2];
    assign wb_req     = req[3];
endmodule

// File: rtl/pe_seq_ctrl_chk.sv
module pe_seq_ctrl_chk #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned OP_W      = 8,
    parameter int unsigned GO_ADDR   = 6,
    parameter int unsigned STAT_ADDR = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        status,
    input logic              host_wr_en,
    input logic              host_rd_en,
    input logic [ADDR_W-1:0] host_addr,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_random,
    input logic              buf_req,
    input logic              buf_ack,
    input logic              alu_req,
    input logic              alu_ack,
    input logic [OP_W-1:0]   alu_op,
    input logic              wb_req,
    input logic              wb_ack
);
    logic [3:0] reqs;
    assign reqs = {wb_req, alu_req, buf_req, mem_req};

    a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));
    a_r5_run_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b01 |-> $countones(reqs) == 1);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b00 |-> reqs == 4'b0000);
    a_r4_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);
    a_r5_fetch_to_unpack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> buf_req);
    a_r5_unpack_to_compute: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req && buf_ack |=> alu_req);
    a_r5_compute_to_wb: assert property (@(posedge clk) disable iff (!rst_n)
        alu_req && alu_ack |=> wb_req);
    a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && wb_ack |=> status == 2'b10 && reqs == 4'b0000);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_en && host_addr == ADDR_W'(STAT_ADDR) && status == 2'b10
        && !(host_wr_en && host_addr == ADDR_W'(GO_ADDR)) |=> status == 2'b00);
    a_r9_instr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b01 && $past(status) == 2'b01 |-> $stable(alu_op) && $stable(mem_random));
endmodule

bind pe_seq_ctrl pe_seq_ctrl_chk #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .GO_ADDR(GO_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .status(st), .host_wr_en(host_wr_en),
    .host_rd_en(host_rd_en), .host_addr(host_addr),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_random(mem_random),
    .buf_req(buf_req), .buf_ack(buf_ack), .alu_req(alu_req), .alu_ack(alu_ack),
    .alu_op(alu_op), .wb_req(wb_req), .wb_ack(wb_ack)
);

// File: tb/pe_seq_ctrl_test.sv
`timescale 1ns/1ps
module pe_seq_ctrl_test;
    localparam int CW   = 8;
    localparam int SATV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [191:0] instr;
    logic        mem_req, mem_random, buf_req, alu_req, wb_req;
    logic [7:0]  alu_op;
    logic [3:0]  ackv = '0;
    logic [3:0]  reqv;

    int tests = 0, fails = 0, cycles = 0;
    int lat[4];
    int wcnt[4];
    logic force_ack = 1'b0;
    logic cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    pe_seq_ctrl #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_rd_en(rd_en),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .instr(instr),
        .mem_req(mem_req), .mem_random(mem_random), .mem_ack(ackv[0]),
        .buf_req(buf_req), .buf_ack(ackv[1]),
        .alu_req(alu_req), .alu_op(alu_op), .alu_ack(ackv[2]),
        .wb_req(wb_req), .wb_ack(ackv[3])
    );
    assign reqv = {wb_req, alu_req, buf_req, mem_req};

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // acknowledge responder: ack after lat[p] waiting cycles
    always @(negedge clk) begin
        for (int p = 0; p < 4; p++) begin
            if (reqv[p]) begin
                ackv[p] = (wcnt[p] >= lat[p]);
                wcnt[p]++;
            end else begin
                ackv[p] = force_ack;
                wcnt[p] = 0;
            end
        end
    end

    // behavioural reference model
    int          m_st, m_ph;
    int          m_cnt[4];
    logic [31:0] m_w[6];
    logic [31:0] m_rd;
    string       m_tag;

    function automatic logic [31:0] m_read(int a);
        if (a < 6)              return m_w[a];
        if (a == 7)             return 32'(m_st);
        if (a >= 8 && a <= 11)  return 32'(m_cnt[a-8]);
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        int a;
        logic go_ok;
        if (!rst_n) begin
            m_st = 0; m_ph = -1; m_rd = '0; m_tag = "R2";
            for (int p = 0; p < 4; p++) m_cnt[p] = 0;
            for (int k = 0; k < 6; k++) m_w[k] = '0;
        end else begin
            a = int'(addr);
            if (rd_en) begin
                m_rd  = m_read(a);
                m_tag = (a < 6) ? "R1" : (a == 7) ? "R7" : (a >= 8 && a <= 11) ? "R8" : "R10";
            end
            go_ok = wr_en && a == 6 && wdata[0] && m_st != 1;
            if (wr_en && a < 6 && m_st != 1) m_w[a] = wdata;
            if (m_st == 1) begin
                if (m_cnt[m_ph] < SATV) m_cnt[m_ph]++;
                if (ackv[m_ph]) begin
                    if (m_ph == 3) begin m_st = 2; m_ph = -1; end
                    else m_ph++;
                end
            end else if (go_ok) begin
                m_st = 1; m_ph = 0;
                for (int p = 0; p < 4; p++) m_cnt[p] = 0;
            end else if (rd_en && a == 7 && m_st == 2) begin
                m_st = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R5 requests", 64'(reqv), (m_st == 1) ? 64'(1 << m_ph) : 64'd0);
            check({m_tag, " rdata"}, 64'(rdata), 64'(m_rd));
            check("R5 alu_op", 64'(alu_op), 64'(m_w[0][7:0]));
            check("R4 mem_random", 64'(mem_random), 64'(m_w[0][8]));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic host_write(int a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_read(int a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = 4'(a);
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic wait_done();
        logic [31:0] d;
        int n = 0;
        do begin host_read(7, d); n++; end while (d != 32'd2 && n < 2000);
        check("R6 status reached Done", 64'(d), 64'd2);
        host_read(7, d);
        check("R7 Done cleared by read", 64'(d), 64'd0);
    endtask

    task automatic go_and_check_fetch();
        host_write(6, 32'd1);
        check("R3 mem_req after start", 64'(mem_req), 64'd1);
    endtask

    initial begin
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin lat[p] = 0; wcnt[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check("R2 requests idle", 64'(reqv), 64'd0);
        host_read(7, d); check("R2 status Idle", 64'(d), 64'd0);
        host_read(8, d); check("R2 counter zero", 64'(d), 64'd0);

        // R1: load and read back all six words
        host_write(0, 32'h1234_003C);
        for (int k = 1; k < 6; k++) host_write(k, 32'hA000_0000 + 32'(k * 32'h111));
        for (int k = 0; k < 6; k++) begin
            host_read(k, d);
            check("R1 word readback", 64'(d), (k == 0) ? 64'h1234_003C : 64'(32'hA000_0000 + 32'(k * 32'h111)));
        end
        check("R1 instr word5 position", 64'(instr[191:160]), 64'hA000_0555);
        host_read(6, d);  check("R10 start address reads zero", 64'(d), 64'd0);
        host_read(14, d); check("R10 unmapped reads zero", 64'(d), 64'd0);

        // R3: start with bit0 clear has no effect
        host_write(6, 32'hFFFF_FFFE);
        check("R3 start bit clear ignored", 64'(reqv), 64'd0);

        // run 1: sequential mode
        lat[0] = 2; lat[1] = 0; lat[2] = 5; lat[3] = 1;
        go_and_check_fetch();
        check("R4 sequential mode", 64'(mem_random), 64'd0);
        check("R5 alu_op decode", 64'(alu_op), 64'h3C);
        host_write(6, 32'd1);              // R3 ignored while running
        host_write(0, 32'h0000_01FF);      // R9 ignored while running
        check("R9 alu_op unchanged", 64'(alu_op), 64'h3C);
        wait_done();
        host_read(0, d);  check("R9 word0 unchanged", 64'(d), 64'h1234_003C);
        host_read(8, d);  check("R8 fetch count", 64'(d), 64'd3);
        host_read(9, d);  check("R8 unpack count", 64'(d), 64'd1);
        host_read(10, d); check("R8 compute count", 64'(d), 64'd6);
        host_read(11, d); check("R8 writeback count", 64'(d), 64'd2);

        // R5: stray acknowledges while idle are ignored
        force_ack = 1'b1;
        repeat (4) @(negedge clk);
        force_ack = 1'b0;
        check("R5 stray acks no request", 64'(reqv), 64'd0);
        host_read(7, d);  check("R5 stray acks status Idle", 64'(d), 64'd0);

        // run 2: random mode, restart directly from Done
        host_write(0, 32'h0000_0181);
        lat[0] = 0; lat[1] = 3; lat[2] = 0; lat[3] = 0;
        go_and_check_fetch();
        check("R4 random mode", 64'(mem_random), 64'd1);
        check("R5 alu_op second", 64'(alu_op), 64'h81);
        while (!wb_req) @(negedge clk);
        @(negedge clk);
        check("R6 requests low at Done", 64'(reqv), 64'd0);
        lat[0] = 0; lat[1] = 0; lat[2] = 300; lat[3] = 0;
        go_and_check_fetch();              // R7 start accepted from Done
        host_read(8, d); check("R8 counters cleared by start", 64'(d), 64'd1);
        wait_done();
        host_read(10, d); check("R8 compute saturates", 64'(d), 64'(SATV));
        host_read(9, d);  check("R8 unpack after restart", 64'(d), 64'd1);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule